// File: doc/BRIEF.md
# Nesting Vectored Interrupt Controller

This block gathers up to 32 level-sensitive interrupt sources and drives two request lines toward a processor. A normal request line `irq_o` serves ordinary handlers. A fast request line `fiq_o` serves sources routed to the fast path. Software can also raise any source by setting a bit in a soft-pending register. A pending source is the OR of its input pin and its soft bit. Sixteen vector slots each hold a handler address word and a control byte. A control byte assigns one source to the slot and says whether the slot is active. A default address serves any source that no active slot claims. A lower slot index means higher priority.

Priority nesting is tracked in hardware. A read of the vector-address register does two things. It returns the handler address for the most urgent pending source. It also raises the current priority level and saves the level it replaced on a per-level stack. A write to the same register pops back to the saved level. Levels run from 0 to 17. Level 16 belongs to the default vector, and level 17 means no handler is in progress.

The slot settings are turned into a registered priority-mask table. A small two-state machine controls the rebuild. `TBL_FRESH` is the idle state, in which the table matches the slots. `TBL_STALE` is entered on any slot write. From `TBL_STALE` the block stays in `TBL_STALE` if another slot write arrives, and otherwise reloads the table and returns to `TBL_FRESH`.

The register interface is a single-cycle bus with a request, a write enable, a byte address and write data. Read data is registered.

Top module: `vic_nest`

## Requirements
- R1: After reset `irq_o` and `fiq_o` are low, the level is 17, and a vector read with nothing pending returns the default address (word 13), which resets to zero.
- R2: A write to word 4 ORs the data into the enable register. A write to word 5 clears the enable bits that are 1 in the data. A read of word 4 returns the enable register.
- R3: A write to word 6 ORs the data into the soft-pending register, and a write to word 7 clears the bits that are 1 in the data. A read of word 6 returns the soft-pending register. A soft bit counts as pending exactly like the matching input pin.
- R4: `irq_o` is high when (pending & enable & ~select & mask[level]) is nonzero. mask[i] is the OR of one-hot source bits of the active slots with index below i, and mask[17] is all ones. Word 0 reads pending & enable & ~select, and word 2 reads the pending vector.
- R5: `fiq_o` is high when (pending & select) is nonzero, whatever the enable register holds. Word 3 is the fast-select register, and word 1 reads pending & select.
- R6: The handler address of slot n is at byte 0x100+4n. Its control byte is at byte 0x200+4n, where bit 5 activates the slot and bits [4:0] name the source. Slot settings reach `irq_o` one cycle after the write cycle, not in the write cycle itself.
- R7: A read of word 12 searches for the smallest i below the current level with pending & mask[i+1] nonzero. On a hit, the current level is saved as level i's previous level, the level becomes i, and slot i's address is returned (the default address for i = 16). With no hit, the address for the current level is returned and the level does not change.
- R8: A write to word 12 ignores its data. When the level is below 17, it restores the level saved for the current level. At level 17 it has no effect.
- R9: Word 13 holds the default handler address and reads it back.
- R10: Writes to word 0 and to unlisted words change nothing. Unlisted words read as zero. Word 8 keeps only data bit 0.
- R11: Words at bytes 0xFE0 to 0xFFC return identification byte k (k = word bits [2:0]) of parameter `ID_VAL`, where byte k is bits [8k+7:8k], zero-extended.
- R12: Read data appears on `bus_rdata` in the cycle after the read request and holds until the next read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, synchronous |
| irq_src | input | NSRC | Level-sensitive source inputs |
| bus_req | input | 1 | Register access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address; bits [11:2] select the word |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Registered read data |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The checker assumes that no bus access occurs while reset is held, and that at most one access arrives per cycle, so a write to word 0 cannot coincide with another write. The nesting properties assume that every pop follows a push made with the same slot layout. The stimulus keeps to this by changing slot control bytes only at level 17 or level 16. The bench also holds every bus request for exactly one cycle, with an idle cycle between requests.

// File: rtl/vic_nest_pkg.sv
package vic_nest_pkg;

    localparam int unsigned ADDR_W = 12;
    localparam int unsigned WORD_W = ADDR_W - 2;

    // word offsets (byte address >> 2)
    localparam logic [WORD_W-1:0] OFS_IRQ_STAT = 10'd0;
    localparam logic [WORD_W-1:0] OFS_FIQ_STAT = 10'd1;
    localparam logic [WORD_W-1:0] OFS_RAW      = 10'd2;
    localparam logic [WORD_W-1:0] OFS_FSEL     = 10'd3;
    localparam logic [WORD_W-1:0] OFS_EN_SET   = 10'd4;
    localparam logic [WORD_W-1:0] OFS_EN_CLR   = 10'd5;
    localparam logic [WORD_W-1:0] OFS_SW_SET   = 10'd6;
    localparam logic [WORD_W-1:0] OFS_SW_CLR   = 10'd7;
    localparam logic [WORD_W-1:0] OFS_PROT     = 10'd8;
    localparam logic [WORD_W-1:0] OFS_VEC      = 10'd12;
    localparam logic [WORD_W-1:0] OFS_DEFVEC   = 10'd13;
    localparam logic [WORD_W-1:0] VADDR_BASE   = 10'h040;
    localparam logic [WORD_W-1:0] VCTL_BASE    = 10'h080;
    localparam logic [WORD_W-1:0] ID_BASE      = 10'h3F8;

    localparam int unsigned CTL_EN_BIT = 5;

    typedef enum logic {
        TBL_FRESH = 1'b0,
        TBL_STALE = 1'b1
    } tbl_state_e;

endpackage

// File: rtl/vic_nest_mask_tbl.sv
module vic_nest_mask_tbl
    import vic_nest_pkg::*;
#(
    parameter int unsigned NSRC  = 32,
    parameter int unsigned NSLOT = 16,
    parameter int unsigned SW    = $clog2(NSRC)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            slot_wr,
    input  logic [NSLOT-1:0]                slot_en,
    input  logic [NSLOT-1:0][SW-1:0]        slot_src,
    output logic [NSLOT+1:0][NSRC-1:0]      tbl
);

    tbl_state_e                  state_q, state_d;
    logic [NSLOT-1:0][NSRC-1:0]  hot;
    logic [NSLOT+1:0][NSRC-1:0]  tbl_d;

    // one-hot source bit per active slot
    for (genvar g = 0; g < NSLOT; g++) begin : g_hot
        assign hot[g] = slot_en[g] ? (NSRC'(1) << slot_src[g]) : '0;
    end

    // cumulative masks: level i sees only slots with index below i
    always_comb begin
        logic [NSRC-1:0] run;
        run      = '0;
        tbl_d[0] = '0;
        for (int j = 0; j < NSLOT; j++) begin
            run        = run | hot[j];
            tbl_d[j+1] = run;
        end
        tbl_d[NSLOT+1] = '1;
    end

    always_comb begin
        unique case (state_q)
            TBL_FRESH: state_d = slot_wr ? TBL_STALE : TBL_FRESH;
            TBL_STALE: state_d = slot_wr ? TBL_STALE : TBL_FRESH;
            default:   state_d = TBL_FRESH;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TBL_FRESH;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl            <= '0;
            tbl[NSLOT+1]   <= '1;
        end else if (state_q == TBL_STALE) begin
            tbl <= tbl_d;
        end
    end

endmodule

// File: rtl/vic_nest_level_stk.sv
module vic_nest_level_stk #(
    parameter int unsigned NSRC  = 32,
    parameter int unsigned NSLOT = 16,
    parameter int unsigned LW    = $clog2(NSLOT + 2)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NSRC-1:0]             pend,
    input  logic [NSLOT+1:0][NSRC-1:0]  tbl,
    input  logic                        push,
    input  logic                        pop,
    output logic [LW-1:0]               cur_lvl,
    output logic [LW-1:0]               sel_lvl
);

    localparam int unsigned   DEPTH = 1 << LW;
    localparam logic [LW-1:0] TOPL  = LW'(NSLOT + 1);

    logic [DEPTH-1:0][LW-1:0] prev_q;
    logic                     hit;
    logic [LW-1:0]            hit_lvl;

    // smallest level i below current with pending & mask[i+1] != 0
    always_comb begin
        hit     = 1'b0;
        hit_lvl = TOPL;
        for (int i = NSLOT; i >= 0; i--) begin
            if ((LW'(i) < cur_lvl) && (|(pend & tbl[i+1]))) begin
                hit     = 1'b1;
                hit_lvl = LW'(i);
            end
        end
    end

    assign sel_lvl = hit ? hit_lvl : cur_lvl;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_lvl <= TOPL;
            prev_q  <= {DEPTH{TOPL}};
        end else if (push && hit) begin
            prev_q[hit_lvl] <= cur_lvl;
            cur_lvl         <= hit_lvl;
        end else if (pop && (cur_lvl < TOPL)) begin
            cur_lvl <= prev_q[cur_lvl];
        end
    end

endmodule

// File: rtl/vic_nest.sv
module vic_nest
    import vic_nest_pkg::*;
#(
    parameter int unsigned NSRC   = 32,
    parameter int unsigned NSLOT  = 16,
    parameter int unsigned DW     = 32,
    parameter logic [63:0] ID_VAL = 64'h5A3C_0F96_C3E1_7B24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_src,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq_o,
    output logic              fiq_o
);

    localparam int unsigned SW  = $clog2(NSRC);
    localparam int unsigned SIW = $clog2(NSLOT);
    localparam int unsigned LW  = $clog2(NSLOT + 2);
    localparam logic [WORD_W-1:0] VADDR_END = VADDR_BASE + WORD_W'(NSLOT);
    localparam logic [WORD_W-1:0] VCTL_END  = VCTL_BASE + WORD_W'(NSLOT);

    logic [NSRC-1:0]              en_q, soft_q, fsel_q, pend;
    logic                         prot_q;
    logic [DW-1:0]                defvec_q;
    logic [NSLOT-1:0][DW-1:0]     vaddr_q;
    logic [NSLOT-1:0][7:0]        vctl_q;
    logic [NSLOT-1:0]             slot_en;
    logic [NSLOT-1:0][SW-1:0]     slot_src;
    logic [NSLOT+1:0][NSRC-1:0]   tbl;
    logic [LW-1:0]                cur_lvl, sel_lvl;
    logic [WORD_W-1:0]            word, voff, coff;
    logic                         rd, wr, slot_wr, push, pop;
    logic [DW-1:0]                sel_vec, rd_mux;

    assign word    = bus_addr[ADDR_W-1:2];
    assign voff    = word - VADDR_BASE;
    assign coff    = word - VCTL_BASE;
    assign rd      = bus_req && !bus_we;
    assign wr      = bus_req && bus_we;
    assign slot_wr = wr && (((word >= VADDR_BASE) && (word < VADDR_END)) ||
                            ((word >= VCTL_BASE)  && (word < VCTL_END)));
    assign push    = rd && (word == OFS_VEC);
    assign pop     = wr && (word == OFS_VEC);
    assign pend    = irq_src | soft_q;

    // per-slot storage and field split
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vaddr_q[g] <= '0;
                vctl_q[g]  <= '0;
            end else if (wr && (word == VADDR_BASE + WORD_W'(g))) begin
                vaddr_q[g] <= bus_wdata;
            end else if (wr && (word == VCTL_BASE + WORD_W'(g))) begin
                vctl_q[g]  <= bus_wdata[7:0];
            end
        end
        assign slot_en[g]  = vctl_q[g][CTL_EN_BIT];
        assign slot_src[g] = vctl_q[g][SW-1:0];
    end

    // control register writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q     <= '0;
            soft_q   <= '0;
            fsel_q   <= '0;
            prot_q   <= 1'b0;
            defvec_q <= '0;
        end else if (wr) begin
            case (word)
                OFS_FSEL:   fsel_q   <= bus_wdata[NSRC-1:0];
                OFS_EN_SET: en_q     <= en_q | bus_wdata[NSRC-1:0];
                OFS_EN_CLR: en_q     <= en_q & ~bus_wdata[NSRC-1:0];
                OFS_SW_SET: soft_q   <= soft_q | bus_wdata[NSRC-1:0];
                OFS_SW_CLR: soft_q   <= soft_q & ~bus_wdata[NSRC-1:0];
                OFS_PROT:   prot_q   <= bus_wdata[0];
                OFS_DEFVEC: defvec_q <= bus_wdata;
                default: ;
            endcase
        end
    end

    vic_nest_mask_tbl #(.NSRC(NSRC), .NSLOT(NSLOT), .SW(SW)) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .slot_wr  (slot_wr),
        .slot_en  (slot_en),
        .slot_src (slot_src),
        .tbl      (tbl)
    );

    vic_nest_level_stk #(.NSRC(NSRC), .NSLOT(NSLOT), .LW(LW)) u_stk (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend    (pend),
        .tbl     (tbl),
        .push    (push),
        .pop     (pop),
        .cur_lvl (cur_lvl),
        .sel_lvl (sel_lvl)
    );

    always_comb begin
        if (sel_lvl >= LW'(NSLOT)) sel_vec = defvec_q;
        else                       sel_vec = vaddr_q[sel_lvl[SIW-1:0]];
    end

    always_comb begin
        rd_mux = '0;
        if ((word >= VADDR_BASE) && (word < VADDR_END)) begin
            rd_mux = vaddr_q[voff[SIW-1:0]];
        end else if ((word >= VCTL_BASE) && (word < VCTL_END)) begin
            rd_mux = DW'(vctl_q[coff[SIW-1:0]]);
        end else if (word >= ID_BASE) begin
            rd_mux = DW'(ID_VAL[{word[2:0], 3'b000} +: 8]);
        end else begin
            case (word)
                OFS_IRQ_STAT: rd_mux = DW'(pend & en_q & ~fsel_q);
                OFS_FIQ_STAT: rd_mux = DW'(pend & fsel_q);
                OFS_RAW:      rd_mux = DW'(pend);
                OFS_FSEL:     rd_mux = DW'(fsel_q);
                OFS_EN_SET:   rd_mux = DW'(en_q);
                OFS_SW_SET:   rd_mux = DW'(soft_q);
                OFS_PROT:     rd_mux = DW'(prot_q);
                OFS_VEC:      rd_mux = sel_vec;
                OFS_DEFVEC:   rd_mux = defvec_q;
                default:      rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)  bus_rdata <= '0;
        else if (rd) bus_rdata <= rd_mux;
    end

    assign irq_o = |(pend & en_q & ~fsel_q & tbl[cur_lvl]);
    assign fiq_o = |(pend & fsel_q);

endmodule

// File: rtl/vic_nest_chk.sv
module vic_nest_chk
    import vic_nest_pkg::*;
#(
    parameter int unsigned NSRC  = 32,
    parameter int unsigned NSLOT = 16,
    parameter int unsigned LW    = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [LW-1:0]     cur_lvl,
    input logic [NSRC-1:0]   en_q,
    input logic [NSRC-1:0]   soft_q,
    input logic [NSRC-1:0]   fsel_q,
    input logic              irq_o,
    input logic              fiq_o
);

    localparam logic [LW-1:0] TOPL = LW'(NSLOT + 1);

    a_r1_level_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        cur_lvl <= TOPL);

    a_r7_push_never_lowers_urgency: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_addr[ADDR_W-1:2] == OFS_VEC)
        |=> cur_lvl <= $past(cur_lvl));

    a_r8_pop_never_raises_urgency: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_addr[ADDR_W-1:2] == OFS_VEC)
        |=> cur_lvl >= $past(cur_lvl));

    a_r4_irq_needs_open_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (cur_lvl != '0));

    a_r4_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ((en_q & ~fsel_q) != '0));

    a_r5_fiq_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_o |-> (fsel_q != '0));

    a_r10_word0_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_addr[ADDR_W-1:2] == OFS_IRQ_STAT)
        |=> ($stable(en_q) && $stable(soft_q) && $stable(fsel_q) && $stable(cur_lvl)));

endmodule

bind vic_nest vic_nest_chk #(.NSRC(NSRC), .NSLOT(NSLOT), .LW(LW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_req  (bus_req),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .cur_lvl  (cur_lvl),
    .en_q     (en_q),
    .soft_q   (soft_q),
    .fsel_q   (fsel_q),
    .irq_o    (irq_o),
    .fiq_o    (fiq_o)
);

// File: tb/vic_nest_test.sv
module vic_nest_test;

    localparam logic [63:0] ID_VAL = 64'h5A3C_0F96_C3E1_7B24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_src = '0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o;

    int          n_tests = 0;
    int          n_fails = 0;
    bit          done = 1'b0;
    logic        rd_seen = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #5 clk = ~clk;

    vic_nest uut (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // driver: one-cycle requests, expected read data queued
    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_req = 1'b0;
    endtask

    task automatic set_src(input int s, input logic v);
        irq_src[s] = v;
        #1;
    endtask

    // monitor: read data is due one cycle after the request (R12)
    always @(posedge clk) rd_seen <= bus_req && !bus_we;

    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                chk("R12 unexpected read data", bus_rdata, 32'hx);
            end else begin
                chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 irq_o after reset", 32'(irq_o), 32'd0);
        chk("R1 fiq_o after reset", 32'(fiq_o), 32'd0);
        bus_read(12'h030, 32'h0, "R1 vector read idle returns default");

        // R9: default vector register
        bus_write(12'h034, 32'hDEF0_0000);
        bus_read(12'h034, 32'hDEF0_0000, "R9 default vector readback");
        bus_read(12'h030, 32'hDEF0_0000, "R9 idle vector read gives default");

        // R2: enable set / clear
        bus_write(12'h010, 32'h0000_0220);
        bus_write(12'h010, 32'h0010_0000);
        bus_read(12'h010, 32'h0010_0220, "R2 enable set accumulates");
        bus_write(12'h014, 32'h0000_0200);
        bus_read(12'h010, 32'h0010_0020, "R2 enable clear");
        bus_write(12'h010, 32'h0000_0200);

        // R4: normal request at level 17, status words
        set_src(20, 1'b1);
        chk("R4 irq_o for enabled pending source", 32'(irq_o), 32'd1);
        bus_read(12'h000, 32'h0010_0000, "R4 irq status word");
        bus_read(12'h008, 32'h0010_0000, "R4 raw pending word");

        // R5: fast path
        bus_write(12'h00C, 32'h0010_0000);
        chk("R5 irq_o drops when routed fast", 32'(irq_o), 32'd0);
        chk("R5 fiq_o for selected source", 32'(fiq_o), 32'd1);
        bus_read(12'h004, 32'h0010_0000, "R5 fiq status word");
        bus_write(12'h014, 32'h0010_0000);
        chk("R5 fiq_o ignores enable", 32'(fiq_o), 32'd1);
        bus_write(12'h00C, 32'h0);
        chk("R5 fiq_o low without select", 32'(fiq_o), 32'd0);
        chk("R2 irq_o low after enable clear", 32'(irq_o), 32'd0);
        set_src(20, 1'b0);

        // R3: soft pending
        bus_write(12'h018, 32'h0000_0020);
        chk("R3 soft bit raises irq_o", 32'(irq_o), 32'd1);
        bus_read(12'h018, 32'h0000_0020, "R3 soft readback");
        bus_write(12'h01C, 32'h0000_0020);
        chk("R3 soft clear drops irq_o", 32'(irq_o), 32'd0);
        bus_read(12'h018, 32'h0, "R3 soft cleared");

        // R6: slot layout: slot0 -> src5, slot3 -> src9
        bus_write(12'h100, 32'hA000_0000);
        bus_write(12'h10C, 32'hA000_0300);
        bus_write(12'h200, 32'h0000_0025);
        bus_write(12'h20C, 32'h0000_0029);
        bus_read(12'h20C, 32'h0000_0029, "R6 control byte readback");
        bus_read(12'h10C, 32'hA000_0300, "R6 slot address readback");

        // R12: read data holds across a write
        bus_write(12'h018, 32'h0);
        chk("R12 rdata holds without read", bus_rdata, 32'hA000_0300);

        // R7 / R8: nesting
        set_src(9, 1'b1);
        chk("R4 irq_o src9 at level 17", 32'(irq_o), 32'd1);
        bus_read(12'h030, 32'hA000_0300, "R7 push to slot3");
        chk("R7 irq_o masked at level 3", 32'(irq_o), 32'd0);
        bus_read(12'h030, 32'hA000_0300, "R7 no hit keeps level 3");
        set_src(5, 1'b1);
        chk("R7 higher slot breaks through", 32'(irq_o), 32'd1);
        bus_read(12'h030, 32'hA000_0000, "R7 push to slot0");
        chk("R7 irq_o masked at level 0", 32'(irq_o), 32'd0);
        bus_write(12'h030, 32'h1234_5678);
        chk("R8 pop back to level 3", 32'(irq_o), 32'd1);
        set_src(5, 1'b0);
        chk("R8 level 3 masks src9", 32'(irq_o), 32'd0);
        bus_write(12'h030, 32'h0);
        chk("R8 pop back to level 17", 32'(irq_o), 32'd1);
        set_src(9, 1'b0);
        chk("R4 irq_o low with nothing pending", 32'(irq_o), 32'd0);
        bus_write(12'h030, 32'h0);
        bus_read(12'h030, 32'hDEF0_0000, "R8 pop at 17 no effect");

        // R6 latency with default level 16
        bus_write(12'h010, 32'h0010_0000);
        set_src(20, 1'b1);
        chk("R4 unclaimed source at level 17", 32'(irq_o), 32'd1);
        bus_read(12'h030, 32'hDEF0_0000, "R7 unclaimed source takes default");
        chk("R7 level 16 masks unclaimed source", 32'(irq_o), 32'd0);
        bus_write(12'h214, 32'h0000_0034);
        chk("R6 table unchanged in write cycle", 32'(irq_o), 32'd0);
        @(negedge clk);
        chk("R6 table updated next cycle", 32'(irq_o), 32'd1);
        bus_write(12'h214, 32'h0000_0014);
        chk("R6 inactive slot old table", 32'(irq_o), 32'd1);
        @(negedge clk);
        chk("R6 inactive slot removed", 32'(irq_o), 32'd0);
        bus_write(12'h030, 32'h0);
        chk("R8 pop from level 16", 32'(irq_o), 32'd1);
        set_src(20, 1'b0);

        // R10: ignored writes, unlisted words, protection bit
        bus_write(12'h000, 32'hFFFF_FFFF);
        bus_read(12'h010, 32'h0010_0220, "R10 word0 write leaves enable");
        bus_read(12'h00C, 32'h0, "R10 word0 write leaves select");
        bus_write(12'h024, 32'hFFFF_FFFF);
        bus_read(12'h024, 32'h0, "R10 unlisted word reads zero");
        bus_read(12'h018, 32'h0, "R10 unlisted write leaves soft");
        chk("R10 unlisted write leaves irq_o", 32'(irq_o), 32'd0);
        bus_write(12'h020, 32'hFFFF_FFFF);
        bus_read(12'h020, 32'h1, "R10 protection keeps bit 0");

        // R11: identification bytes
        bus_read(12'hFE0, {24'h0, ID_VAL[7:0]},   "R11 id byte 0");
        bus_read(12'hFEC, {24'h0, ID_VAL[31:24]}, "R11 id byte 3");
        bus_read(12'hFFC, {24'h0, ID_VAL[63:56]}, "R11 id byte 7");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) chk("R12 reads left unanswered", 32'(exp_q.size()), 32'd0);
        finish_run();
    end

endmodule